// File: doc/BRIEF.md
# Framebuffer pixel format transfer unit

This block copies a rectangular image from a source framebuffer to a destination framebuffer and changes the pixel encoding on the way. Four encodings are understood on both sides: 32-bit RGBA, 24-bit RGB, 16-bit 5-5-5-1 and 16-bit 4-4-4-4. Each source pixel is first widened to four 8-bit channels (red, green, blue, alpha). It is then narrowed into the destination encoding. An optional halving mode keeps every other source pixel in each row, so the destination row is half the programmed output width.

Software, or a sequencer, places the settings on the configuration pins and pulses `start`. The block copies the settings on that edge and walks the image in row-major order. For each pixel it issues one read request, waits for that read's data, and then issues one write. At the end it raises a single-cycle completion interrupt. Both memory request channels use valid/ready. A request holds its valid, address and data unchanged until the cycle in which ready is high, and the request is taken on that cycle. Only one read is outstanding at a time. The read return (`rd_rsp_valid`) has no ready signal: the block always accepts it while it waits, and memory may return data any number of cycles after the request.

Top module: `fbx_xfer`

## Requirements
- R1: A 32-bit RGBA source pixel (format code 0) holds alpha in read-data bits 7:0, blue in 15:8, green in 23:16 and red in 31:24. These are the four bytes in order of rising address.
- R2: For a 16-bit source pixel (bits 15:0 of the read data), each field is widened to 8 bits by repeating its own top bits.
  - Format code 2: red is in 15:11, green in 10:6, blue in 5:1 and a 1-bit alpha in bit 0. The alpha bit becomes 0x00 or 0xFF.
  - Format code 3: red is in 15:12, green in 11:8, blue in 7:4 and alpha in 3:0.
- R3: A 24-bit RGB source pixel (format code 1) holds blue in bits 7:0, green in 15:8 and red in 23:16. Its alpha is taken as 0xFF.
- R4: Each destination write carries the pixel in `wr_data` starting at bit 0, with `wr_bytes` giving its size in bytes:
  - Code 0: 4 bytes, packed as alpha, blue, green, red from bit 0 upward.
  - Code 1: 3 bytes, packed as blue, green, red.
  - Code 2: 2 bytes, made of the top 5 bits of red, green and blue followed by the top bit of alpha, with red in bits 15:11.
  - Code 3: 2 bytes, made of the top nibbles of red, green, blue and alpha, with red in bits 15:12.
- R5: Pixels are visited in row-major order. With effective width E, skip k (1 or 2), source pixel size sB and destination pixel size dB, pixel (x, y) is read from `src_addr + (y*src_width + x*k)*sB` and written to `dst_addr + (y*E + x)*dB`.
- R6: With `halve` set, E is `dst_width/2` rounded down and k is 2. With `halve` clear, E is `dst_width` and k is 1.
- R7: A source format code from 4 to 7 yields a pixel with all four channels zero, and the source is stepped in 4-byte units.
- R8: A destination format code from 4 to 7 produces no writes. The reads still take place and the transfer still ends with the interrupt.
- R9: `done_irq` is high for exactly one cycle once the last pixel is finished, and `busy` is high in that cycle. If E or the height is zero, there are no memory requests and the interrupt follows `start` by one cycle.
- R10: The settings are captured on the accepted `start`. A `start` pulse while `busy` is high is ignored, and so are later changes to the settings.
- R11: A request that is not accepted keeps its valid and its address (and, for writes, its data) unchanged. A read request and a write are never offered in the same cycle.
- R12: After reset, `busy`, `done_irq`, `rd_req_valid` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| cfg_src_addr | input | ADDR_W | Source byte address |
| cfg_dst_addr | input | ADDR_W | Destination byte address |
| cfg_src_width | input | DIM_W | Source row length in pixels |
| cfg_dst_width | input | DIM_W | Programmed output width in pixels |
| cfg_height | input | DIM_W | Number of rows |
| cfg_src_fmt | input | 3 | Source encoding code |
| cfg_dst_fmt | input | 3 | Destination encoding code |
| cfg_halve | input | 1 | Keep every other source pixel and halve the width |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion interrupt |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 32 | Four bytes starting at the read address, lowest address in bits 7:0 |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 32 | Packed pixel, lowest byte first |
| wr_bytes | output | 3 | Number of valid bytes in wr_data |

## Verification
The bench sends every source encoding through at least one destination encoding, so that a swapped byte or field order shows up as a mismatch in a named channel. The source memory is a byte function of the address: every channel value differs, and the 1-bit alpha of the 5-5-5-1 encoding takes both values. A halving run with an odd programmed width separates correct floor rounding and pixel skipping from plain copying. The same run shows whether the source row pitch is applied. Unsupported codes on each side, a zero-height image and a start pulse during a transfer (with changed settings) each show whether the block suppresses output, completes, and keeps the captured settings. Ready signals that stall in different patterns test that requests are held while stalled.

// File: rtl/fbx_pkg.sv
package fbx_pkg;

  localparam logic [2:0] PF_RGBA8  = 3'd0;
  localparam logic [2:0] PF_RGB8   = 3'd1;
  localparam logic [2:0] PF_RGB5A1 = 3'd2;
  localparam logic [2:0] PF_RGBA4  = 3'd3;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
    logic [7:0] a;
  } rgba_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RREQ  = 3'd1,
    ST_RWAIT = 3'd2,
    ST_WRITE = 3'd3,
    ST_FIN   = 3'd4
  } xfer_state_e;

  // Bytes consumed per source pixel; unknown codes step by 4.
  function automatic logic [2:0] src_pix_bytes(input logic [2:0] f);
    case (f)
      PF_RGB8:              return 3'd3;
      PF_RGB5A1, PF_RGBA4:  return 3'd2;
      default:              return 3'd4;
    endcase
  endfunction

  // Bytes produced per destination pixel; zero marks an unsupported code.
  function automatic logic [2:0] dst_pix_bytes(input logic [2:0] f);
    case (f)
      PF_RGBA8:             return 3'd4;
      PF_RGB8:              return 3'd3;
      PF_RGB5A1, PF_RGBA4:  return 3'd2;
      default:              return 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen4(input logic [3:0] v);
    return {v, v};
  endfunction

endpackage

// File: rtl/fbx_unpack.sv
module fbx_unpack
  import fbx_pkg::*;
(
  input  logic [2:0]  fmt,
  input  logic [31:0] raw,
  output rgba_t       px
);
  logic [15:0] half;
  assign half = raw[15:0];

  always_comb begin
    px = '0;
    case (fmt)
      PF_RGBA8: begin
        px.a = raw[7:0];
        px.b = raw[15:8];
        px.g = raw[23:16];
        px.r = raw[31:24];
      end
      PF_RGB8: begin
        px.b = raw[7:0];
        px.g = raw[15:8];
        px.r = raw[23:16];
        px.a = 8'hFF;
      end
      PF_RGB5A1: begin
        px.r = widen5(half[15:11]);
        px.g = widen5(half[10:6]);
        px.b = widen5(half[5:1]);
        px.a = {8{half[0]}};
      end
      PF_RGBA4: begin
        px.r = widen4(half[15:12]);
        px.g = widen4(half[11:8]);
        px.b = widen4(half[7:4]);
        px.a = widen4(half[3:0]);
      end
      default: px = '0;
    endcase
  end
endmodule

// File: rtl/fbx_pack.sv
module fbx_pack
  import fbx_pkg::*;
(
  input  logic [2:0]  fmt,
  input  rgba_t       px,
  output logic [31:0] word,
  output logic [2:0]  nbytes
);
  always_comb begin
    word   = '0;
    nbytes = dst_pix_bytes(fmt);
    case (fmt)
      PF_RGBA8:  word = {px.r, px.g, px.b, px.a};
      PF_RGB8:   word = {8'h00, px.r, px.g, px.b};
      PF_RGB5A1: word = {16'h0000, px.r[7:3], px.g[7:3], px.b[7:3], px.a[7]};
      PF_RGBA4:  word = {16'h0000, px.r[7:4], px.g[7:4], px.b[7:4], px.a[7:4]};
      default:   word = '0;
    endcase
  end
endmodule

// File: rtl/fbx_walker.sv
module fbx_walker #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [DIM_W-1:0]  src_width,
  input  logic [DIM_W-1:0]  eff_width,
  input  logic [DIM_W-1:0]  height,
  input  logic [2:0]        src_bytes,
  input  logic [2:0]        dst_bytes,
  input  logic              halve,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic              last_pix
);
  logic [ADDR_W-1:0] row_base, pitch_q, sstep_q, dstep_q;
  logic [DIM_W-1:0]  x_q, y_q, w_q, h_q;
  logic [ADDR_W-1:0] w_ext, pitch_d, next_row;
  logic              row_end;

  // Row pitch by shift-add: pixel sizes are 2, 3 or 4 bytes.
  assign w_ext = ADDR_W'(src_width);
  always_comb begin
    case (src_bytes)
      3'd2:    pitch_d = w_ext << 1;
      3'd3:    pitch_d = (w_ext << 1) + w_ext;
      default: pitch_d = w_ext << 2;
    endcase
  end

  assign row_end  = (x_q == w_q - DIM_W'(1));
  assign last_pix = row_end && (y_q == h_q - DIM_W'(1));
  assign next_row = row_base + pitch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q      <= '0;
      y_q      <= '0;
      w_q      <= '0;
      h_q      <= '0;
      row_base <= '0;
      pitch_q  <= '0;
      sstep_q  <= '0;
      dstep_q  <= '0;
      src_ptr  <= '0;
      dst_ptr  <= '0;
    end else if (load) begin
      x_q      <= '0;
      y_q      <= '0;
      w_q      <= eff_width;
      h_q      <= height;
      row_base <= src_addr;
      src_ptr  <= src_addr;
      dst_ptr  <= dst_addr;
      pitch_q  <= pitch_d;
      sstep_q  <= ADDR_W'(src_bytes) << halve;
      dstep_q  <= ADDR_W'(dst_bytes);
    end else if (advance) begin
      dst_ptr <= dst_ptr + dstep_q;
      if (row_end) begin
        x_q      <= '0;
        y_q      <= y_q + DIM_W'(1);
        row_base <= next_row;
        src_ptr  <= next_row;
      end else begin
        x_q     <= x_q + DIM_W'(1);
        src_ptr <= src_ptr + sstep_q;
      end
    end
  end
endmodule

// File: rtl/fbx_xfer.sv
module fbx_xfer
  import fbx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_src_addr,
  input  logic [ADDR_W-1:0] cfg_dst_addr,
  input  logic [DIM_W-1:0]  cfg_src_width,
  input  logic [DIM_W-1:0]  cfg_dst_width,
  input  logic [DIM_W-1:0]  cfg_height,
  input  logic [2:0]        cfg_src_fmt,
  input  logic [2:0]        cfg_dst_fmt,
  input  logic              cfg_halve,
  output logic              busy,
  output logic              done_irq,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [2:0]        wr_bytes
);
  xfer_state_e       state_q;
  logic [2:0]        src_fmt_q, dst_fmt_q;
  logic [DIM_W-1:0]  eff_w;
  logic              empty, load, advance, last_pix, dst_ok;
  logic [ADDR_W-1:0] src_ptr, dst_ptr;
  rgba_t             pix;
  logic [31:0]       packed_word, data_q;
  logic [2:0]        packed_bytes, bytes_q;

  assign eff_w  = cfg_halve ? (cfg_dst_width >> 1) : cfg_dst_width;
  assign empty  = (eff_w == '0) || (cfg_height == '0);
  assign load   = (state_q == ST_IDLE) && start;
  assign dst_ok = (dst_pix_bytes(dst_fmt_q) != 3'd0);
  assign advance = ((state_q == ST_WRITE) && wr_ready) ||
                   ((state_q == ST_RWAIT) && rd_rsp_valid && !dst_ok);

  fbx_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .advance   (advance),
    .src_addr  (cfg_src_addr),
    .dst_addr  (cfg_dst_addr),
    .src_width (cfg_src_width),
    .eff_width (eff_w),
    .height    (cfg_height),
    .src_bytes (src_pix_bytes(cfg_src_fmt)),
    .dst_bytes (dst_pix_bytes(cfg_dst_fmt)),
    .halve     (cfg_halve),
    .src_ptr   (src_ptr),
    .dst_ptr   (dst_ptr),
    .last_pix  (last_pix)
  );

  fbx_unpack u_unpack (
    .fmt (src_fmt_q),
    .raw (rd_rsp_data),
    .px  (pix)
  );

  fbx_pack u_pack (
    .fmt    (dst_fmt_q),
    .px     (pix),
    .word   (packed_word),
    .nbytes (packed_bytes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      src_fmt_q <= '0;
      dst_fmt_q <= '0;
      data_q    <= '0;
      bytes_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          src_fmt_q <= cfg_src_fmt;
          dst_fmt_q <= cfg_dst_fmt;
          state_q   <= empty ? ST_FIN : ST_RREQ;
        end
        ST_RREQ: if (rd_req_ready) state_q <= ST_RWAIT;
        ST_RWAIT: if (rd_rsp_valid) begin
          data_q  <= packed_word;
          bytes_q <= packed_bytes;
          if (dst_ok)        state_q <= ST_WRITE;
          else if (last_pix) state_q <= ST_FIN;
          else               state_q <= ST_RREQ;
        end
        ST_WRITE: if (wr_ready) state_q <= last_pix ? ST_FIN : ST_RREQ;
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done_irq     = (state_q == ST_FIN);
  assign rd_req_valid = (state_q == ST_RREQ);
  assign rd_req_addr  = src_ptr;
  assign wr_valid     = (state_q == ST_WRITE);
  assign wr_addr      = dst_ptr;
  assign wr_data      = data_q;
  assign wr_bytes     = bytes_q;
endmodule

// File: rtl/fbx_xfer_chk.sv
module fbx_xfer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done_irq,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [2:0]        wr_bytes
);
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R11
  one_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid));

  // R9
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R9
  irq_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> busy);

  // R4
  wr_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_bytes >= 3'd2 && wr_bytes <= 3'd4));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !wr_valid);
endmodule

bind fbx_xfer fbx_xfer_chk #(.ADDR_W(ADDR_W)) u_fbx_xfer_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done_irq     (done_irq),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .wr_bytes     (wr_bytes)
);

// File: tb/fbx_xfer_bench.sv
module fbx_xfer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [AW-1:0] cfg_src_addr = 0, cfg_dst_addr = 0;
  logic [DW-1:0] cfg_src_width = 0, cfg_dst_width = 0, cfg_height = 0;
  logic [2:0] cfg_src_fmt = 0, cfg_dst_fmt = 0;
  logic cfg_halve = 0;
  logic busy, done_irq, rd_req_valid, wr_valid;
  logic rd_req_ready = 0, rd_rsp_valid = 0, wr_ready = 0;
  logic [AW-1:0] rd_req_addr, wr_addr;
  logic [31:0] rd_rsp_data = 0, wr_data;
  logic [2:0] wr_bytes;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbx_xfer #(.ADDR_W(AW), .DIM_W(DW)) u_fbx_xfer (.*);

  int n_tests = 0, n_fail = 0;
  int irq_cnt = 0, wr_cnt = 0, cyc = 0;
  int stall_mode = 0;
  logic [AW-1:0] exp_rd_q[$];
  logic [AW-1:0] exp_wa_q[$];
  logic [31:0]   exp_wd_q[$];
  logic [2:0]    exp_wb_q[$];
  string cur_tag = "";

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd29 + (a >> 7) + 32'd91;
    return t[7:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s [%s]: actual=%h expected=%h", req, what, cur_tag, act, exp);
    end
  endtask

  // Memory model and monitor: sample mid-cycle, drive just after the edge.
  initial begin
    bit acc_rd;
    int lat;
    bit pend;
    logic [AW-1:0] pa;
    pend = 0; lat = 0; pa = 0;
    forever begin
      @(negedge clk);
      acc_rd = rd_req_valid && rd_req_ready;
      if (acc_rd) begin
        if (exp_rd_q.size() == 0)
          check(0, "R5", "unexpected read addr", rd_req_addr, 0);
        else begin
          logic [AW-1:0] e;
          e = exp_rd_q.pop_front();
          check(rd_req_addr == e, "R5", "read addr", rd_req_addr, e);
        end
        pa = rd_req_addr;
      end
      if (wr_valid && wr_ready) begin
        wr_cnt++;
        if (exp_wa_q.size() == 0)
          check(0, "R8", "unexpected write", wr_addr, 0);
        else begin
          logic [AW-1:0] ea; logic [31:0] ed; logic [2:0] eb;
          ea = exp_wa_q.pop_front(); ed = exp_wd_q.pop_front(); eb = exp_wb_q.pop_front();
          check(wr_addr == ea, "R5", "write addr", wr_addr, ea);
          check(wr_data == ed, "R4", "write data", wr_data, ed);
          check(wr_bytes == eb, "R4", "write size", {29'd0, wr_bytes}, {29'd0, eb});
        end
      end
      if (done_irq) irq_cnt++;
      @(posedge clk); #1;
      cyc++;
      rd_rsp_valid = 0;
      if (acc_rd) begin pend = 1; lat = cyc % 3; end
      else if (pend) begin
        if (lat == 0) begin
          pend = 0;
          rd_rsp_valid = 1;
          rd_rsp_data = {mbyte(pa + 3), mbyte(pa + 2), mbyte(pa + 1), mbyte(pa)};
        end else lat--;
      end
      if (stall_mode == 0) begin rd_req_ready = 1; wr_ready = 1; end
      else begin
        rd_req_ready = (cyc % 3) != 1;
        wr_ready = (cyc % 4) != 2;
      end
    end
  end

  // Independent reference of the conversion rules.
  task automatic expect_xfer(input logic [2:0] sf, input logic [2:0] df,
                             input logic [AW-1:0] sa, input logic [AW-1:0] da,
                             input int sw, input int dw, input int h, input bit hv);
    int sb, db, k, e;
    sb = (sf == 1) ? 3 : (sf == 2 || sf == 3) ? 2 : 4;
    db = (df == 0) ? 4 : (df == 1) ? 3 : (df == 2 || df == 3) ? 2 : 0;
    k = hv ? 2 : 1;
    e = hv ? dw / 2 : dw;
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < e; x++) begin
        logic [AW-1:0] ra;
        logic [7:0] b0, b1, b2, b3, r, g, b, a;
        logic [31:0] w;
        ra = sa + AW'((y * sw + x * k) * sb);
        exp_rd_q.push_back(ra);
        b0 = mbyte(ra); b1 = mbyte(ra + 1); b2 = mbyte(ra + 2); b3 = mbyte(ra + 3);
        case (sf)
          3'd0: begin a = b0; b = b1; g = b2; r = b3; end                // R1
          3'd1: begin b = b0; g = b1; r = b2; a = 8'hFF; end            // R3
          3'd2: begin                                                     // R2
            r = {b1[7:3], b1[7:5]};
            g = {b1[2:0], b0[7:6], b1[2:0]};
            b = {b0[5:1], b0[5:3]};
            a = b0[0] ? 8'hFF : 8'h00;
          end
          3'd3: begin                                                     // R2
            r = {b1[7:4], b1[7:4]}; g = {b1[3:0], b1[3:0]};
            b = {b0[7:4], b0[7:4]}; a = {b0[3:0], b0[3:0]};
          end
          default: begin r = 0; g = 0; b = 0; a = 0; end                 // R7
        endcase
        case (df)
          3'd0: w = {r, g, b, a};
          3'd1: w = {8'h0, r, g, b};
          3'd2: w = {16'h0, r[7:3], g[7:3], b[7:3], a[7]};
          3'd3: w = {16'h0, r[7:4], g[7:4], b[7:4], a[7:4]};
          default: w = 0;
        endcase
        if (db != 0) begin
          exp_wa_q.push_back(da + AW'((y * e + x) * db));
          exp_wd_q.push_back(w);
          exp_wb_q.push_back(3'(db));
        end
      end
    end
  endtask

  task automatic run_xfer(input string tag, input logic [2:0] sf, input logic [2:0] df,
                          input logic [AW-1:0] sa, input logic [AW-1:0] da,
                          input int sw, input int dw, input int h, input bit hv,
                          input int exp_writes, input bit inject);
    int irq0, wr0, n;
    cur_tag = tag;
    expect_xfer(sf, df, sa, da, sw, dw, h, hv);
    irq0 = irq_cnt; wr0 = wr_cnt;
    @(posedge clk); #2;
    cfg_src_fmt = sf; cfg_dst_fmt = df; cfg_src_addr = sa; cfg_dst_addr = da;
    cfg_src_width = DW'(sw); cfg_dst_width = DW'(dw); cfg_height = DW'(h); cfg_halve = hv;
    start = 1;
    @(posedge clk); #2;
    start = 0;
    if (inject) begin
      // R10: a second start with other settings while busy must be ignored
      repeat (5) @(posedge clk); #2;
      cfg_src_fmt = 3; cfg_dst_fmt = 1; cfg_src_addr = 'h7700; cfg_dst_addr = 'h9900;
      cfg_src_width = 3; cfg_dst_width = 2; cfg_height = 1; cfg_halve = 0;
      start = 1;
      @(posedge clk); #2;
      start = 0;
    end
    n = 0;
    while (irq_cnt == irq0 && n < 20000) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
    check(irq_cnt == irq0 + 1, "R9", "one interrupt per transfer", irq_cnt - irq0, 1);
    check(!busy, "R9", "busy low after completion", busy, 0);
    check(wr_cnt - wr0 == exp_writes, "R8", "write count", wr_cnt - wr0, exp_writes);
    check(exp_wa_q.size() == 0 && exp_rd_q.size() == 0, "R5", "all expected traffic seen",
          exp_wa_q.size() + exp_rd_q.size(), 0);
    exp_rd_q.delete(); exp_wa_q.delete(); exp_wd_q.delete(); exp_wb_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int irq0;
    repeat (3) @(posedge clk); #2;
    cur_tag = "reset";
    check(!busy && !done_irq && !rd_req_valid && !wr_valid, "R12", "reset outputs",
          {busy, done_irq, rd_req_valid, wr_valid}, 0);
    rst_n = 1;
    // R1 to R4: format pairs
    run_xfer("rgba8->rgb8",   3'd0, 3'd1, 'h1000, 'h8000, 4, 4, 2, 0, 8, 0);
    stall_mode = 1;
    run_xfer("rgb5a1->rgba8", 3'd2, 3'd0, 'h2002, 'h8100, 5, 5, 3, 0, 15, 0);
    // R6: halving with odd width and a wider source row
    run_xfer("rgba4->rgb5a1 halve", 3'd3, 3'd2, 'h3000, 'h8400, 7, 5, 2, 1, 4, 0);
    run_xfer("rgb8->rgba4",   3'd1, 3'd3, 'h4001, 'h8800, 3, 3, 3, 0, 9, 0);
    run_xfer("rgba8->rgba8 halve", 3'd0, 3'd0, 'h4800, 'h8900, 6, 6, 2, 1, 6, 0);
    // R7: unknown source code
    run_xfer("src code 5",    3'd5, 3'd0, 'h5000, 'h8a00, 3, 3, 1, 0, 3, 0);
    // R8: unknown destination code, reads only
    run_xfer("dst code 6",    3'd0, 3'd6, 'h5100, 'h8b00, 2, 2, 2, 0, 0, 0);
    // R10: start during busy
    run_xfer("restart ignored", 3'd2, 3'd1, 'h6000, 'h8c00, 4, 4, 3, 0, 12, 1);
    // R9: zero-height image, interrupt one cycle after start
    cur_tag = "empty";
    irq0 = irq_cnt;
    @(posedge clk); #2;
    cfg_height = 0; cfg_dst_width = 4; start = 1;
    @(posedge clk); #2;
    start = 0;
    check(done_irq && busy, "R9", "empty transfer interrupt timing", {busy, done_irq}, 2'b11);
    repeat (4) @(negedge clk);
    check(irq_cnt == irq0 + 1, "R9", "empty transfer single interrupt", irq_cnt - irq0, 1);
    check(!rd_req_valid && !busy, "R9", "empty transfer no traffic", rd_req_valid, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule